// File: doc/BRIEF.md
# USB OUT Endpoint DMA Drain Controller

This block holds received packets for one bulk OUT endpoint and lets a byte-wide DMA engine empty them. The USB side writes up to 64 bytes into a free buffer, one byte per write strobe, and then commits the packet with a done strobe and its length. Two buffers work as a ping-pong pair. The block keeps a DMA request high while the buffer it is reading still holds unread bytes. Each byte-sized acknowledge takes one byte.

A small CPU register interface has two addresses. Address 0 bit 0 is the DMA mode enable. Address 1 bit 0 is a read-finish trigger that releases the buffer being read. With DMA mode on, the block releases a buffer by itself in the cycle its final byte is acknowledged, and a packet of length zero is dropped. With DMA mode off, software releases buffers, and a packet of length zero is kept and reported.

Top module: `usb_out_dma_drain`

## Requirements
- R1: `dma_req` is high exactly when the buffer being read is committed and still holds unread bytes. This holds in both modes. It is low after a buffer is drained or released with no other committed data.
- R2: `dma_size` encodes 0 = byte, 1 = word, 2 = longword. An acknowledge with a size other than byte takes no byte, and `size_err` pulses for one cycle after it.
- R3: With DMA mode on, a committed packet of length zero is ignored. No request, no `zlp_irq`, no change of buffer, and the next packet's data follows in order.
- R4: With DMA mode on, `rf_auto` is high during the acknowledge that takes the last byte of a packet. After that edge the buffer is free for the USB side again.
- R5: The automatic release fires once per packet, for full and for short packets alike. Packets of 64, 64 and 22 bytes give exactly three events.
- R6: After any release, reading moves to the other buffer. If that buffer is committed, the request stays high and bytes come out in arrival order.
- R7: A trigger write (address 1, bit 0 = 1) while DMA mode is on is ignored and makes `rf_err` pulse for one cycle after the write. With DMA mode off, no error is flagged.
- R8: With DMA mode off, reading the last byte does not release the buffer. A trigger write releases it and discards any unread bytes.
- R9: With DMA mode off, a packet of length zero is committed, raises `zlp_irq` for one cycle after its done strobe, requests nothing, and is released by a trigger write.
- R10: After reset: DMA mode off, `dma_req` low, `usb_rdy` high, all flag outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 1 | 0 = mode register, 1 = read-finish trigger |
| cpu_wbit | input | 1 | Write data bit |
| usb_wr | input | 1 | Write one received byte |
| usb_wdata | input | DW | Received byte |
| usb_pkt_done | input | 1 | Packet commit strobe |
| usb_pkt_len | input | clog2(MAX_PKT+1) | Packet length, 0 to MAX_PKT |
| usb_rdy | output | 1 | Fill buffer is free |
| dma_ack | input | 1 | DMA read acknowledge |
| dma_size | input | 2 | Access size of the acknowledge |
| dma_req | output | 1 | Unread bytes are waiting |
| dma_rdata | output | DW | Byte at the read position |
| rf_auto | output | 1 | Automatic release in this cycle |
| zlp_irq | output | 1 | Zero-length packet kept (manual mode) |
| rf_err | output | 1 | Trigger written while DMA mode on |
| size_err | output | 1 | Non-byte acknowledge seen |

## Verification
The hardest state to reach is both buffers full while a release happens. The request must stay high across the switch, with no idle cycle and no byte lost. The stimulus gets there by committing two packets before draining starts, with random gaps between acknowledges. Zero-length packets are mixed into the random stream, so drops meet ping-pong switching at varied fill levels.

// File: rtl/usb_odd_pkg.sv
package usb_odd_pkg;

  typedef enum logic [1:0] {
    XS_BYTE = 2'd0,
    XS_WORD = 2'd1,
    XS_LONG = 2'd2
  } xfer_size_e;

  localparam logic ADDR_MODE = 1'b0;
  localparam logic ADDR_TRIG = 1'b1;

  // next ping-pong slot, wrapping at n
  function automatic int unsigned next_slot(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // true when the byte at rptr is the final one of a cnt-byte packet
  function automatic logic is_final(int unsigned rptr, int unsigned cnt);
    return (rptr + 1) == cnt;
  endfunction

  // a length larger than the buffer is cut to the buffer size
  function automatic int unsigned clamp_len(int unsigned len, int unsigned lim);
    return (len > lim) ? lim : len;
  endfunction

endpackage

// File: rtl/pkt_store.sv
module pkt_store #(
  parameter int NBUF  = 2,
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int SW    = 1,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_buf,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [SW-1:0] rd_buf,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] rd_each [NBUF];

  for (genvar b = 0; b < NBUF; b++) begin : g_bank
    logic [DW-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_buf == SW'(b)) bank[wr_addr] <= wr_data;
    end
    assign rd_each[b] = bank[rd_addr];
  end

  assign rd_data = rd_each[rd_buf];

endmodule

// File: rtl/pkt_fill.sv
module pkt_fill
  import usb_odd_pkg::*;
#(
  parameter int NBUF  = 2,
  parameter int DEPTH = 64,
  parameter int SW    = 1,
  parameter int AW    = 6,
  parameter int CW    = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dma_en,
  input  logic            usb_wr,
  input  logic            usb_pkt_done,
  input  logic [CW-1:0]   usb_pkt_len,
  input  logic [NBUF-1:0] full_vec,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [SW-1:0]   wsel,
  output logic            commit,
  output logic [CW-1:0]   commit_len,
  output logic            zlp_take
);

  logic [CW-1:0] wptr;
  logic          slot_busy, accept, zero_len, zlp_drop;

  assign slot_busy  = full_vec[wsel];
  assign wr_en      = usb_wr && !slot_busy && (wptr < CW'(DEPTH));
  assign wr_addr    = wptr[AW-1:0];
  assign zero_len   = (usb_pkt_len == '0);
  assign accept     = usb_pkt_done && !slot_busy;
  assign zlp_drop   = accept && zero_len && dma_en;
  assign commit     = accept && !zlp_drop;
  assign zlp_take   = commit && zero_len;
  assign commit_len = CW'(clamp_len(usb_pkt_len, DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      wsel <= '0;
    end else begin
      if (usb_pkt_done) wptr <= '0;
      else if (wr_en)   wptr <= wptr + 1'b1;
      if (commit) wsel <= SW'(next_slot(wsel, NBUF));
    end
  end

endmodule

// File: rtl/buf_drain.sv
module buf_drain
  import usb_odd_pkg::*;
#(
  parameter int NBUF = 2,
  parameter int SW   = 1,
  parameter int CW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dma_en,
  input  logic            pop_req,
  input  logic            trig_rf,
  input  logic            commit,
  input  logic [SW-1:0]   commit_buf,
  input  logic [CW-1:0]   commit_len,
  output logic [NBUF-1:0] full_vec,
  output logic [SW-1:0]   rsel,
  output logic [CW-1:0]   rptr,
  output logic            has_data,
  output logic            pop,
  output logic            auto_rel
);

  logic [CW-1:0] cnt_each [NBUF];
  logic          man_rel, rel_any;

  assign has_data = full_vec[rsel] && (rptr < cnt_each[rsel]);
  assign pop      = pop_req && has_data;
  assign auto_rel = pop && dma_en && is_final(rptr, cnt_each[rsel]);
  assign man_rel  = trig_rf && full_vec[rsel];
  assign rel_any  = auto_rel || man_rel;

  for (genvar b = 0; b < NBUF; b++) begin : g_slot
    logic          full_q;
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        cnt_q  <= '0;
      end else if (commit && commit_buf == SW'(b)) begin
        full_q <= 1'b1;
        cnt_q  <= commit_len;
      end else if (rel_any && rsel == SW'(b)) begin
        full_q <= 1'b0;
      end
    end
    assign full_vec[b]  = full_q;
    assign cnt_each[b]  = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel <= '0;
      rptr <= '0;
    end else if (rel_any) begin
      rsel <= SW'(next_slot(rsel, NBUF));
      rptr <= '0;
    end else if (pop) begin
      rptr <= rptr + 1'b1;
    end
  end

endmodule

// File: rtl/usb_out_dma_drain.sv
module usb_out_dma_drain
  import usb_odd_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int NBUF    = 2,
  parameter int DW      = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cpu_wr,
  input  logic                           cpu_addr,
  input  logic                           cpu_wbit,
  input  logic                           usb_wr,
  input  logic [DW-1:0]                  usb_wdata,
  input  logic                           usb_pkt_done,
  input  logic [$clog2(MAX_PKT+1)-1:0]   usb_pkt_len,
  output logic                           usb_rdy,
  input  logic                           dma_ack,
  input  logic [1:0]                     dma_size,
  output logic                           dma_req,
  output logic [DW-1:0]                  dma_rdata,
  output logic                           rf_auto,
  output logic                           zlp_irq,
  output logic                           rf_err,
  output logic                           size_err
);

  localparam int CW = $clog2(MAX_PKT + 1);
  localparam int AW = $clog2(MAX_PKT);
  localparam int SW = (NBUF > 1) ? $clog2(NBUF) : 1;

  logic            dma_en;
  logic            trig_wr, byte_ack, trig_rf;
  logic [NBUF-1:0] full_vec;
  logic            wr_en, commit, zlp_take, pop_evt;
  logic [AW-1:0]   wr_addr;
  logic [SW-1:0]   wsel, rsel;
  logic [CW-1:0]   commit_len, rptr;

  assign trig_wr  = cpu_wr && (cpu_addr == ADDR_TRIG) && cpu_wbit;
  assign trig_rf  = trig_wr && !dma_en;
  assign byte_ack = dma_ack && (dma_size == XS_BYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_en   <= 1'b0;
      rf_err   <= 1'b0;
      size_err <= 1'b0;
      zlp_irq  <= 1'b0;
    end else begin
      if (cpu_wr && cpu_addr == ADDR_MODE) dma_en <= cpu_wbit;
      rf_err   <= trig_wr && dma_en;
      size_err <= dma_ack && (dma_size != XS_BYTE);
      zlp_irq  <= zlp_take;
    end
  end

  pkt_fill #(.NBUF(NBUF), .DEPTH(MAX_PKT), .SW(SW), .AW(AW), .CW(CW)) u_fill (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .usb_wr(usb_wr),
    .usb_pkt_done(usb_pkt_done), .usb_pkt_len(usb_pkt_len), .full_vec(full_vec),
    .wr_en(wr_en), .wr_addr(wr_addr), .wsel(wsel), .commit(commit),
    .commit_len(commit_len), .zlp_take(zlp_take)
  );

  buf_drain #(.NBUF(NBUF), .SW(SW), .CW(CW)) u_drain (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .pop_req(byte_ack),
    .trig_rf(trig_rf), .commit(commit), .commit_buf(wsel), .commit_len(commit_len),
    .full_vec(full_vec), .rsel(rsel), .rptr(rptr), .has_data(dma_req),
    .pop(pop_evt), .auto_rel(rf_auto)
  );

  pkt_store #(.NBUF(NBUF), .DEPTH(MAX_PKT), .DW(DW), .SW(SW), .AW(AW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_buf(wsel), .wr_addr(wr_addr), .wr_data(usb_wdata),
    .rd_buf(rsel), .rd_addr(rptr[AW-1:0]), .rd_data(dma_rdata)
  );

  assign usb_rdy = !full_vec[wsel];

endmodule

// File: rtl/usb_out_dma_drain_chk.sv
module usb_out_dma_drain_chk #(
  parameter int SW = 1,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dma_en,
  input logic          trig_wr,
  input logic          dma_ack,
  input logic [1:0]    dma_size,
  input logic          usb_pkt_done,
  input logic [CW-1:0] usb_pkt_len,
  input logic          dma_req,
  input logic          rf_auto,
  input logic          rf_err,
  input logic          size_err,
  input logic          zlp_irq,
  input logic          pop_evt,
  input logic [SW-1:0] rsel,
  input logic [SW-1:0] wsel
);

  // R1: a byte is only taken while the request is up
  p_pop_under_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |-> dma_req);

  // R2: wide acknowledges take nothing and are flagged
  p_wide_nopop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && dma_size != 2'd0) |-> !pop_evt);
  p_wide_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && dma_size != 2'd0) |=> size_err);

  // R3: dropped empty packet leaves the fill slot and flag alone
  p_zlp_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && usb_pkt_done && usb_pkt_len == '0) |=> ($stable(wsel) && !zlp_irq));

  // R4: automatic release only in DMA mode and only on a taken byte
  p_auto_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_auto |-> (dma_en && pop_evt));

  // R6: release moves the read side to another buffer
  p_auto_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_auto |=> (rsel != $past(rsel)));

  // R7: trigger in DMA mode is flagged and does not move the read side
  p_trig_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && dma_en) |=> rf_err);
  p_trig_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && dma_en && !rf_auto) |=> $stable(rsel));

endmodule

bind usb_out_dma_drain usb_out_dma_drain_chk #(.SW(SW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .trig_wr(trig_wr),
  .dma_ack(dma_ack), .dma_size(dma_size), .usb_pkt_done(usb_pkt_done),
  .usb_pkt_len(usb_pkt_len), .dma_req(dma_req), .rf_auto(rf_auto),
  .rf_err(rf_err), .size_err(size_err), .zlp_irq(zlp_irq),
  .pop_evt(pop_evt), .rsel(rsel), .wsel(wsel)
);

// File: tb/usb_out_dma_drain_tb.sv
module usb_out_dma_drain_tb;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 1'b0, cpu_addr = 1'b0, cpu_wbit = 1'b0;
  logic       usb_wr = 1'b0, usb_pkt_done = 1'b0;
  logic [7:0] usb_wdata = '0;
  logic [6:0] usb_pkt_len = '0;
  logic       usb_rdy, dma_req, rf_auto, zlp_irq, rf_err, size_err;
  logic       dma_ack = 1'b0;
  logic [1:0] dma_size = 2'd0;
  logic [7:0] dma_rdata;

  int checks = 0, bad = 0, auto_seen = 0;
  logic [7:0] exp_q[$];
  int         len_q[$];

  always #(CLK_P/2) clk = ~clk;

  usb_out_dma_drain u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wbit(cpu_wbit),
    .usb_wr(usb_wr), .usb_wdata(usb_wdata), .usb_pkt_done(usb_pkt_done),
    .usb_pkt_len(usb_pkt_len), .usb_rdy(usb_rdy), .dma_ack(dma_ack), .dma_size(dma_size),
    .dma_req(dma_req), .dma_rdata(dma_rdata), .rf_auto(rf_auto), .zlp_irq(zlp_irq),
    .rf_err(rf_err), .size_err(size_err)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // last byte of the front packet is the one that must trigger release
  function automatic bit expect_auto();
    return len_q.size() > 0 && len_q[0] == 1;
  endfunction

  task automatic cpu_write(input logic a, input logic d);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wbit = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic send_pkt(input int n, input bit dma_mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); usb_wr = 1'b1; usb_wdata = 8'($urandom);
      exp_q.push_back(usb_wdata);
    end
    @(negedge clk); usb_wr = 1'b0; usb_pkt_done = 1'b1; usb_pkt_len = 7'(n);
    @(negedge clk); usb_pkt_done = 1'b0;
    if (n > 0 || !dma_mode) len_q.push_back(n);
  endtask

  task automatic drain(input int gap_pct);
    int guard = 0;
    bit ea;
    while (exp_q.size() > 0 && guard < 5000) begin
      @(negedge clk); dma_ack = 1'b0; guard++;
      if ($urandom_range(0, 99) < gap_pct) continue;
      if (!dma_req) begin
        chk(1'b0, "R1/R6 request dropped with data pending", 0, 1);
        break;
      end
      chk(dma_rdata == exp_q[0], "R6 byte order", dma_rdata, exp_q[0]);
      dma_ack = 1'b1; dma_size = 2'd0; #1;
      ea = expect_auto();
      chk(rf_auto == ea, "R4 automatic release", rf_auto, ea);
      if (rf_auto) auto_seen++;
      void'(exp_q.pop_front());
      len_q[0] = len_q[0] - 1;
      if (len_q[0] == 0) void'(len_q.pop_front());
    end
    @(negedge clk); dma_ack = 1'b0;
    chk(dma_req == 1'b0, "R1 idle after drain", dma_req, 0);
  endtask

  task automatic ack_byte(output logic [7:0] d, output logic a);
    @(negedge clk); dma_ack = 1'b1; dma_size = 2'd0; #1;
    d = dma_rdata; a = rf_auto;
    @(negedge clk); dma_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [7:0] d, e;
    logic a;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(dma_req == 1'b0, "R10 req", dma_req, 0);
    chk(usb_rdy == 1'b1, "R10 rdy", usb_rdy, 1);
    chk({rf_auto, zlp_irq, rf_err, size_err} == 4'b0, "R10 flags",
        {rf_auto, zlp_irq, rf_err, size_err}, 0);

    cpu_write(1'b0, 1'b1);

    // R5 and R6: 64 + 64 + 22 with both buffers full before draining
    auto_seen = 0;
    send_pkt(64, 1'b1);
    chk(dma_req == 1'b1, "R1 request after commit", dma_req, 1);
    send_pkt(64, 1'b1);
    chk(usb_rdy == 1'b0, "R6 both buffers held", usb_rdy, 0);
    drain(0);
    send_pkt(22, 1'b1);
    drain(30);
    chk(auto_seen == 3, "R5 release count", auto_seen, 3);

    // R3 zero-length packet dropped in DMA mode
    send_pkt(0, 1'b1);
    chk(dma_req == 1'b0, "R3 no request", dma_req, 0);
    chk(zlp_irq == 1'b0, "R3 no flag", zlp_irq, 0);
    chk(usb_rdy == 1'b1, "R3 slot free", usb_rdy, 1);
    send_pkt(5, 1'b1);
    drain(0);

    // R2 wide acknowledges
    send_pkt(3, 1'b1);
    for (int sz = 1; sz <= 2; sz++) begin
      @(negedge clk); dma_ack = 1'b1; dma_size = 2'(sz);
      @(negedge clk); dma_ack = 1'b0; dma_size = 2'd0;
      chk(size_err == 1'b1, "R2 size flag", size_err, 1);
      chk(dma_rdata == exp_q[0], "R2 nothing taken", dma_rdata, exp_q[0]);
      chk(dma_req == 1'b1, "R2 request kept", dma_req, 1);
    end
    drain(0);

    // R7 trigger while DMA mode on
    auto_seen = 0;
    send_pkt(4, 1'b1);
    cpu_write(1'b1, 1'b1);
    chk(rf_err == 1'b1, "R7 error flag", rf_err, 1);
    chk(dma_req == 1'b1, "R7 buffer kept", dma_req, 1);
    chk(dma_rdata == exp_q[0], "R7 position kept", dma_rdata, exp_q[0]);
    drain(0);
    chk(auto_seen == 1, "R5 short packet release", auto_seen, 1);

    // random traffic in DMA mode
    for (int it = 0; it < 30; it++) begin
      n = ($urandom_range(0, 5) == 0) ? 0 : $urandom_range(1, 64);
      send_pkt(n, 1'b1);
      if (n == 0) chk(zlp_irq == 1'b0, "R3 random zero length", zlp_irq, 0);
      if ($urandom_range(0, 1) == 1) send_pkt($urandom_range(1, 64), 1'b1);
      drain(25);
    end

    // R8 manual mode
    cpu_write(1'b0, 1'b0);
    exp_q.delete(); len_q.delete();
    send_pkt(3, 1'b0);
    for (int i = 0; i < 3; i++) begin
      ack_byte(d, a);
      e = exp_q.pop_front();
      chk(d == e, "R8 manual data", d, e);
      chk(a == 1'b0, "R8 no automatic release", a, 0);
    end
    chk(dma_req == 1'b0, "R1 drained buffer", dma_req, 0);
    send_pkt(4, 1'b0);
    chk(dma_req == 1'b0, "R8 buffer still held", dma_req, 0);
    chk(usb_rdy == 1'b0, "R8 both held", usb_rdy, 0);
    cpu_write(1'b1, 1'b1);
    chk(rf_err == 1'b0, "R7 no error in manual mode", rf_err, 0);
    chk(dma_req == 1'b1, "R8 release moves on", dma_req, 1);
    chk(dma_rdata == exp_q[0], "R8 next packet", dma_rdata, exp_q[0]);
    ack_byte(d, a);
    cpu_write(1'b1, 1'b1);
    chk(dma_req == 1'b0, "R8 rest discarded", dma_req, 0);
    chk(usb_rdy == 1'b1, "R8 slot returned", usb_rdy, 1);

    // R9 zero-length packet kept in manual mode
    exp_q.delete(); len_q.delete();
    send_pkt(0, 1'b0);
    chk(zlp_irq == 1'b1, "R9 flag", zlp_irq, 1);
    chk(dma_req == 1'b0, "R9 no request", dma_req, 0);
    @(negedge clk);
    chk(zlp_irq == 1'b0, "R9 single pulse", zlp_irq, 0);
    cpu_write(1'b1, 1'b1);
    send_pkt(2, 1'b0);
    chk(dma_req == 1'b1, "R9 after release", dma_req, 1);
    chk(dma_rdata == exp_q[0], "R9 data after release", dma_rdata, exp_q[0]);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule